// File: doc/BRIEF.md
# Packed Byte Dot-Product Accumulator

This block multiplies two packed words lane by lane as four unsigned 8-bit pairs, adds the four products, and adds a full 32-bit accumulator operand. The sum wraps modulo 2^32 and is registered, so it appears one clock after the operands are presented with `in_valid`.

Each multiplicand word is rebuilt before the multiply from two 16-bit halves of itself. A low select bit picks the half that feeds lanes x and y. A high select bit picks the half that feeds lanes z and w. Because the two choices are independent, one half may feed both lane pairs. The swizzle is applied to every value on the source ports, small constants included. Select bit 2 of each vector belongs to the accumulator operand and has no effect.

Top module: `dot4_u8_acc`

## Requirements
- R1: Lanes x and y of source A come from bits [7:0] and [15:8] of the half picked by `sel_lo[0]`. For source B the bit is `sel_lo[1]`. A select value of 0 picks bits 15:0 and a value of 1 picks bits 31:16.
- R2: Lanes z and w of source A come from bits [7:0] and [15:8] of the half picked by `sel_hi[0]`. For source B the bit is `sel_hi[1]`. The encoding is the same as in R1.
- R3: `result` equals the sum of the four unsigned 8x8 lane products plus `src_c`, taken modulo 2^32. There is no saturation and no overflow flag.
- R4: `sel_lo[2]` and `sel_hi[2]` have no effect on `result`. `src_c` is always added unmodified.
- R5: `out_valid` equals the `in_valid` of the previous clock. When `in_valid` was high, `result` shows the value computed from the operands of that cycle.
- R6: While `rst_n` is low at a clock edge, `out_valid` and `result` are cleared to 0 at that edge.
- R7: A clock edge with `in_valid` low leaves `result` unchanged.
- R8: Small values get no bypass of the swizzle. With A=1, B=0x04030201, C=0 and `sel_hi`=3'b111, the result is 1 for `sel_lo`=3'b000 and 0 for `sel_lo`=3'b001. With `sel_lo`=3'b000 and `sel_hi`=3'b110, the result is 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands valid this cycle |
| src_a | input | 32 | Packed multiplicand word A |
| src_b | input | 32 | Packed multiplicand word B |
| src_c | input | 32 | Accumulator addend |
| sel_lo | input | 3 | Half select for lanes x/y (bit0 A, bit1 B, bit2 ignored) |
| sel_hi | input | 3 | Half select for lanes z/w (bit0 A, bit1 B, bit2 ignored) |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Registered dot-product sum |

## Verification
Every result is due exactly one rising edge after its operands. The bench drives operands on a falling edge, lets one rising edge pass, and reads `result` and `out_valid` on the next falling edge. Idle cycles check that `out_valid` drops and that `result` holds on that same one-edge schedule. Reset checks are read on the falling edge after a reset edge.

// File: rtl/dot4_pkg.sv
// dot4_pkg: shared sizes and lane numbering for the packed byte dot unit.
// Assumes two 16-bit halves per 32-bit word and two bytes per half.
package dot4_pkg;
    localparam int BYTE_W  = 8;
    localparam int LANES   = 4;
    localparam int WORD_W  = BYTE_W * LANES;
    localparam int ACC_W   = 32;
    localparam int NSRC    = 3;
    // Lane positions inside an assembled lane vector.
    localparam int LANE_X  = 0;
    localparam int LANE_Y  = 1;
    localparam int LANE_Z  = 2;
    localparam int LANE_W  = 3;
endpackage

// File: rtl/dot4_half_swizzle.sv
// dot4_half_swizzle: builds four byte lanes from one packed word.
// The lower lane pair and the upper lane pair each take a 16-bit half
// chosen by its own select bit (0 = low half, 1 = high half).
// Assumes WORD_W is four bytes; purely combinational.
module dot4_half_swizzle #(
    parameter int BYTE_W = dot4_pkg::BYTE_W,
    parameter int LANES  = dot4_pkg::LANES,
    localparam int HALF_W = 2 * BYTE_W,
    localparam int WORD_W = BYTE_W * LANES
) (
    input  logic [WORD_W-1:0] word_in,
    input  logic              pick_lo,
    input  logic              pick_hi,
    output logic [WORD_W-1:0] lanes_out
);
    localparam int PAIRS = LANES / 2;

    logic [HALF_W-1:0] half_lo_src;
    logic [HALF_W-1:0] half_hi_src;
    logic [PAIRS-1:0]  pair_pick;

    // Choose the half feeding the x/y pair.
    always_comb half_lo_src = pick_lo ? word_in[WORD_W-1 -: HALF_W] : word_in[HALF_W-1:0];
    // Choose the half feeding the z/w pair.
    always_comb half_hi_src = pick_hi ? word_in[WORD_W-1 -: HALF_W] : word_in[HALF_W-1:0];

    assign pair_pick = {pick_hi, pick_lo};

    genvar p;
    generate
        for (p = 0; p < PAIRS; p++) begin : g_pair
            logic [HALF_W-1:0] chosen;
            // Route the selected half of this pair onto two adjacent lanes.
            always_comb begin
                chosen = (p == 0) ? half_lo_src : half_hi_src;
                lanes_out[p*HALF_W +: HALF_W] = chosen;
            end
        end
    endgenerate

    logic unused_pick;
    assign unused_pick = ^pair_pick;
endmodule

// File: rtl/dot4_lane_mac.sv
// dot4_lane_mac: unsigned lane-by-lane multiply, adder tree, and addend.
// Sum wraps to ACC_W bits; no saturation. Purely combinational.
module dot4_lane_mac #(
    parameter int BYTE_W = dot4_pkg::BYTE_W,
    parameter int LANES  = dot4_pkg::LANES,
    parameter int ACC_W  = dot4_pkg::ACC_W,
    localparam int WORD_W = BYTE_W * LANES,
    localparam int PROD_W = 2 * BYTE_W
) (
    input  logic [WORD_W-1:0] lanes_a,
    input  logic [WORD_W-1:0] lanes_b,
    input  logic [ACC_W-1:0]  addend,
    output logic [ACC_W-1:0]  sum_out
);
    logic [PROD_W-1:0] prod [LANES];

    genvar k;
    generate
        for (k = 0; k < LANES; k++) begin : g_mul
            // One unsigned 8x8 multiplier per lane.
            always_comb prod[k] = lanes_a[k*BYTE_W +: BYTE_W] * lanes_b[k*BYTE_W +: BYTE_W];
        end
    endgenerate

    // Accumulate all lane products onto the addend, modulo 2^ACC_W.
    always_comb begin
        sum_out = addend;
        for (int i = 0; i < LANES; i++) begin
            sum_out = sum_out + ACC_W'(prod[i]);
        end
    end
endmodule

// File: rtl/dot4_u8_acc.sv
// dot4_u8_acc: four-lane unsigned byte dot product plus 32-bit addend,
// with a per-source 16-bit half swizzle and one output register stage.
// Select bit 2 (addend) is accepted but ignored. Sync active-low reset.
module dot4_u8_acc #(
    parameter int BYTE_W = dot4_pkg::BYTE_W,
    parameter int LANES  = dot4_pkg::LANES,
    parameter int ACC_W  = dot4_pkg::ACC_W,
    parameter int NSRC   = dot4_pkg::NSRC,
    localparam int WORD_W = BYTE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] src_a,
    input  logic [WORD_W-1:0] src_b,
    input  logic [ACC_W-1:0]  src_c,
    input  logic [NSRC-1:0]   sel_lo,
    input  logic [NSRC-1:0]   sel_hi,
    output logic              out_valid,
    output logic [ACC_W-1:0]  result
);
    localparam int NMUL = 2;

    logic [WORD_W-1:0] mul_word  [NMUL];
    logic [WORD_W-1:0] mul_lanes [NMUL];
    logic [ACC_W-1:0]  sum_next;

    assign mul_word[0] = src_a;
    assign mul_word[1] = src_b;

    genvar s;
    generate
        for (s = 0; s < NMUL; s++) begin : g_src
            dot4_half_swizzle #(.BYTE_W(BYTE_W), .LANES(LANES)) u_swz (
                .word_in  (mul_word[s]),
                .pick_lo  (sel_lo[s]),
                .pick_hi  (sel_hi[s]),
                .lanes_out(mul_lanes[s])
            );
        end
    endgenerate

    dot4_lane_mac #(.BYTE_W(BYTE_W), .LANES(LANES), .ACC_W(ACC_W)) u_mac (
        .lanes_a(mul_lanes[0]),
        .lanes_b(mul_lanes[1]),
        .addend (src_c),
        .sum_out(sum_next)
    );

    // Output stage: valid follows input, result loads only on valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= sum_next;
            end
        end
    end

    // Addend select bits are intentionally ignored.
    logic unused_addend_sel;
    assign unused_addend_sel = ^{sel_lo[NSRC-1:NMUL], sel_hi[NSRC-1:NMUL]};
endmodule

// File: rtl/dot4_u8_acc_chk.sv
// dot4_u8_acc_chk: port-level properties for dot4_u8_acc, bound below.
// Expected sums come from a separate per-lane model of the select rules.
module dot4_u8_acc_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] src_a,
    input logic [31:0] src_b,
    input logic [31:0] src_c,
    input logic [2:0]  sel_lo,
    input logic [2:0]  sel_hi,
    input logic        out_valid,
    input logic [31:0] result
);
    function automatic logic [7:0] pick_byte(input logic [31:0] w, input logic sel, input logic upper);
        logic [15:0] h;
        h = sel ? w[31:16] : w[15:0];
        return upper ? h[15:8] : h[7:0];
    endfunction

    logic [31:0] model_sum;
    // Reference sum for R1/R2/R3 built from lane rules.
    always_comb begin
        model_sum = src_c
            + 32'(pick_byte(src_a, sel_lo[0], 1'b0) * pick_byte(src_b, sel_lo[1], 1'b0))
            + 32'(pick_byte(src_a, sel_lo[0], 1'b1) * pick_byte(src_b, sel_lo[1], 1'b1))
            + 32'(pick_byte(src_a, sel_hi[0], 1'b0) * pick_byte(src_b, sel_hi[1], 1'b0))
            + 32'(pick_byte(src_a, sel_hi[0], 1'b1) * pick_byte(src_b, sel_hi[1], 1'b1));
    end

    p_sum_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> result == $past(model_sum));

    p_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    p_reset_r6: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == 32'd0));
endmodule

bind dot4_u8_acc dot4_u8_acc_chk u_chk (.*);

// File: tb/dot4_u8_acc_bench.sv
// dot4_u8_acc_bench: directed corners plus seeded random vectors.
module dot4_u8_acc_bench;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] src_a = '0, src_b = '0, src_c = '0;
    logic [2:0]  sel_lo = '0, sel_hi = '0;
    logic        out_valid;
    logic [31:0] result;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dot4_u8_acc u_dot4_u8_acc (.*);

    function automatic logic [7:0] lane(input logic [31:0] w, input logic sel, input logic up);
        logic [15:0] h;
        h = sel ? w[31:16] : w[15:0];
        return up ? h[15:8] : h[7:0];
    endfunction

    function automatic logic [31:0] expect_sum(input logic [31:0] a, input logic [31:0] b,
                                               input logic [31:0] c, input logic [2:0] lo,
                                               input logic [2:0] hi);
        logic [31:0] s;
        s = c;
        s = s + 32'(lane(a, lo[0], 0)) * 32'(lane(b, lo[1], 0));
        s = s + 32'(lane(a, lo[0], 1)) * 32'(lane(b, lo[1], 1));
        s = s + 32'(lane(a, hi[0], 0)) * 32'(lane(b, hi[1], 0));
        s = s + 32'(lane(a, hi[0], 1)) * 32'(lane(b, hi[1], 1));
        return s;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Drive on a falling edge, pass one rising edge, sample on the next falling edge.
    task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
                         input logic [2:0] lo, input logic [2:0] hi, input string req);
        src_a = a; src_b = b; src_c = c; sel_lo = lo; sel_hi = hi; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(req, result, expect_sum(a, b, c, lo, hi));
        check("R5", {31'd0, out_valid}, 32'd1);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        void'($urandom(32'h5eed_1234));
        @(negedge clk);
        src_a = 32'hFFFF_FFFF; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R6 result", result, 32'd0);
        check("R6 valid", {31'd0, out_valid}, 32'd0);
        rst_n = 1'b1;

        // R8 and R1/R2 directed vectors with a small constant in source A.
        apply(32'd1, 32'h0403_0201, 32'd0, 3'b000, 3'b111, "R8 base");
        check("R8 value", result, 32'd1);
        apply(32'd1, 32'h0403_0201, 32'd0, 3'b001, 3'b111, "R1 lo sel A");
        check("R8 lo swizzle", result, 32'd0);
        apply(32'd1, 32'h0403_0201, 32'd0, 3'b000, 3'b110, "R2 hi sel A");
        check("R8 hi swizzle", result, 32'd4);
        apply(32'h0000_0100, 32'h0403_0201, 32'd0, 3'b010, 3'b011, "R1 lo sel B");
        check("R1 lane y", result, 32'd4);
        apply(32'h0100_0000, 32'h0403_0201, 32'd7, 3'b000, 3'b001, "R2 lane w");
        check("R2 lane w", result, 32'd9);

        // R3 wrap modulo 2^32.
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b000, 3'b111, "R3 wrap");
        check("R3 wrap value", result, 32'd260099);

        // R4 addend select bits ignored.
        apply(32'h1234_5678, 32'h9ABC_DEF0, 32'h0000_1000, 3'b001, 3'b010, "R4 base");
        held = result;
        apply(32'h1234_5678, 32'h9ABC_DEF0, 32'h0000_1000, 3'b101, 3'b110, "R4 toggled");
        check("R4 same", result, held);

        // R7 hold while idle.
        held = result;
        src_a = 32'hDEAD_BEEF; src_c = 32'h1; in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R7 hold", result, held);
        check("R5 idle", {31'd0, out_valid}, 32'd0);

        // Random vectors over R1..R4.
        for (int i = 0; i < 300; i++) begin
            apply($urandom, $urandom, $urandom, 3'($urandom), 3'($urandom), "R3 random");
        end

        // R6 reset in mid-stream.
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R6 mid result", result, 32'd0);
        check("R6 mid valid", {31'd0, out_valid}, 32'd0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule